// File: doc/BRIEF.md
# Channel Status LED Scanner

This block lights a small LED matrix that shows which of eight output channels are switched on. The LEDs sit at the crossings of four row lines and two column lines. Row lines are active-low enables, as an open-drain pull-down would drive them. Column lines are active-high sources. Each row stands for a fixed pair of channels. The block lights one row at a time, in turn, so each row is lit for a quarter of the refresh period.

A prescaler counts system clocks to set how long each row slot lasts. The slot length is derived from the system clock frequency and the wanted refresh rate, which defaults to 780 Hz. The channel pair for a row is captured once, at the start of that row's slot. The first clock of every slot leaves every line dark, so no LED in the old row glows while the new row comes up. Deasserting the enable, or reset, turns every line off. Enabling again starts the scan from row 0.

Top module: `status_matrix_drv`

## Requirements
- R1: While reset is asserted, and afterwards while `en` is low, `row_n` reads 4'b1111 (all rows released) and `col` reads 2'b00.
- R2: One clock after `en` is sampled low, every row is released and every column is dark. Changes on `status` have no visible effect until `en` rises again.
- R3: At most one bit of `row_n` is low in any cycle.
- R4: Rows are scanned in the order 0, 1, 2, 3, 0, ... Each row slot lasts SLOT = CLK_HZ / (REFRESH_HZ * 4) clocks, so the full refresh period is 4 * SLOT clocks.
- R5: The first clock of every slot is blank: all rows are released and both columns read 0. A change from one active row to another always passes through such a cycle.
- R6: In slot r, the active row is `row_n[r]` (low). `col[0]` shows channel bit `status[2r]` and `col[1]` shows `status[2r+1]`. Bit 0 of `status` is the first channel.
- R7: A column is high only while a row is active and its channel bit is 1. With no row active, both columns read 0.
- R8: The channel pair for a slot is taken from `status` at the clock edge that begins the slot. A change during the slot is not shown before that row's next slot, and `col` is constant during the lit part of a slot.
- R9: The first clock edge that samples `en` high after a disabled period begins the blank cycle of row 0's slot. Rows 0 through 3 then follow the timing of R4.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Scan enable; low turns the matrix off |
| status | input | ROWS*COLS (8) | Channel on/off vector, bit 0 = first channel |
| row_n | output | ROWS (4) | Row enables, active low |
| col | output | COLS (2) | Column sources, active high |

## Verification
A wrong slot counter or prescaler limit shows as a row edge at the wrong clock. That is visible at `row_n` on the first row change, SLOT clocks after enable. A wrong row index shows as the wrong row going low, or as a column pair from another row's bits, within one slot. A missing blank cycle or a late capture of `status` shows only at slot boundaries, or after `status` changes in the middle of a slot. The bench therefore compares every cycle of whole refresh periods against a cycle-count model and changes `status` in the middle of slots.

// File: rtl/smd_pkg.sv
package smd_pkg;

  // Clocks per row slot for a given clock, refresh rate and row count.
  function automatic int slot_cycles(input longint clk_hz, input longint refresh_hz,
                                     input int rows);
    longint q;
    q = clk_hz / (refresh_hz * rows);
    if (q < 2) q = 2;
    return int'(q);
  endfunction

  // Successor row index, wrapping after the last row.
  function automatic int next_row(input int idx, input int rows);
    return (idx >= rows - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/smd_prescaler.sv
module smd_prescaler #(
  parameter int SLOT_CYC = 10,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             running_o,
  output logic             start_o,
  output logic             lit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             wrap_w;

  assign wrap_w    = run_q && (cnt_q == CNT_W'(SLOT_CYC - 1));
  // Next clock edge begins a new slot (first slot after enable or a wrap).
  assign start_o   = en && (!run_q || wrap_w);
  assign running_o = run_q;
  assign lit_o     = run_q && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (start_o) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the counter never passes the last clock of the slot
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOT_CYC - 1));

  // R5: a new slot always opens dark
  a_r5_slot_opens_dark: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !lit_o);
endmodule

// File: rtl/smd_row_seq.sv
module smd_row_seq #(
  parameter int ROWS  = 4,
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             running,
  input  logic             start,
  output logic [ROW_W-1:0] idx_o,
  output logic [ROW_W-1:0] idx_next_o
);
  logic [ROW_W-1:0] idx_q;

  assign idx_next_o = running ? ROW_W'(smd_pkg::next_row(int'(idx_q), ROWS)) : '0;
  assign idx_o      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (!en)    idx_q <= '0;
    else if (start)  idx_q <= idx_next_o;
  end

  // R4: while scanning, the row index only steps forward by one (with wrap)
  a_r4_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && en) |=> (int'(idx_q) == smd_pkg::next_row(int'($past(idx_q)), ROWS)));

  // R9: the first slot after enable is row 0
  a_r9_restart_row0: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && en) |=> (idx_q == '0));
endmodule

// File: rtl/smd_col_latch.sv
module smd_col_latch #(
  parameter int ROWS  = 4,
  parameter int COLS  = 2,
  parameter int ROW_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 start,
  input  logic [ROW_W-1:0]     idx_next,
  input  logic [ROWS*COLS-1:0] status,
  output logic [COLS-1:0]      pair_o
);
  logic [COLS-1:0] pair_q;
  logic [COLS-1:0] pick_w;

  assign pick_w = status[int'(idx_next)*COLS +: COLS];
  assign pair_o = pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pair_q <= '0;
    else if (!en)   pair_q <= '0;
    else if (start) pair_q <= pick_w;
  end

  // R8: the captured pair holds for the whole slot
  a_r8_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start) |=> $stable(pair_q));
endmodule

// File: rtl/status_matrix_drv.sv
module status_matrix_drv #(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint REFRESH_HZ = 780,
  parameter int     ROWS       = 4,
  parameter int     COLS       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [ROWS*COLS-1:0] status,
  output logic [ROWS-1:0]      row_n,
  output logic [COLS-1:0]      col
);
  localparam int SLOT_CYC = smd_pkg::slot_cycles(CLK_HZ, REFRESH_HZ, ROWS);
  localparam int CNT_W    = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
  localparam int ROW_W    = (ROWS > 2) ? $clog2(ROWS) : 1;

  logic             running_w;
  logic             start_w;
  logic             lit_w;
  logic [ROW_W-1:0] idx_w;
  logic [ROW_W-1:0] idx_next_w;
  logic [COLS-1:0]  pair_w;

  smd_prescaler #(.SLOT_CYC(SLOT_CYC), .CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .running_o(running_w), .start_o(start_w), .lit_o(lit_w)
  );

  smd_row_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .en(en), .running(running_w), .start(start_w),
    .idx_o(idx_w), .idx_next_o(idx_next_w)
  );

  smd_col_latch #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_cols (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start_w),
    .idx_next(idx_next_w), .status(status), .pair_o(pair_w)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n[r] = ~(lit_w && (int'(idx_w) == r));
  end

  assign col = lit_w ? pair_w : '0;

  // R3: never more than one row pulled low
  a_r3_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_n));

  // R5: switching between two rows always passes through a dark cycle
  a_r5_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    ((~row_n != '0) && ($past(~row_n) != '0)) |-> (row_n == $past(row_n)));

  // R2: a low enable darkens the matrix on the next clock
  a_r2_disable_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((row_n == '1) && (col == '0)));

  // R7: columns are dark whenever no row is active
  a_r7_cols_need_row: assert property (@(posedge clk) disable iff (!rst_n)
    (row_n == '1) |-> (col == '0));
endmodule

// File: tb/status_matrix_drv_tb.sv
module status_matrix_drv_tb;
  localparam int SLOT = 10;   // 4000 / (100 * 4)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] status = 8'h00;
  logic [3:0] row_n;
  logic [1:0] col;
  int         n_checks = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  status_matrix_drv #(.CLK_HZ(4000), .REFRESH_HZ(100), .ROWS(4), .COLS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .status(status), .row_n(row_n), .col(col)
  );

  task automatic check(input string req, input logic [3:0] exp_r, input logic [1:0] exp_c);
    n_checks++;
    if (row_n !== exp_r || col !== exp_c) begin
      n_fail++;
      $display("FAIL %s t=%0t row_n=%b col=%b expected row_n=%b col=%b",
               req, $time, row_n, col, exp_r, exp_c);
    end
  endtask

  // R1: reset state and idle with enable low
  task automatic t_reset();
    check("R1", 4'hF, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", 4'hF, 2'b00);
    end
  endtask

  // R3 R4 R5 R6 R7 R8 R9: scan from enable, cycle-exact model,
  // optional status change at cycle chg_at
  task automatic t_scan(input logic [7:0] pat, input int ncyc, input int chg_at,
                        input logic [7:0] newpat);
    logic [1:0] snap;
    int         row;
    status = pat;
    en = 1'b1;
    snap = 2'b00;
    for (int n = 0; n < ncyc; n++) begin
      row = (n / SLOT) % 4;
      if (n % SLOT == 0) snap = status[2*row +: 2];
      @(posedge clk);
      @(negedge clk);
      if (n % SLOT == 0) check("R5/R9", 4'hF, 2'b00);
      else               check("R4/R6/R7/R8", ~(4'b0001 << row), snap);
      if (n == chg_at) status = newpat;
    end
  endtask

  // R2: disable darkens in one clock and status is ignored while off
  task automatic t_disable();
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2", 4'hF, 2'b00);
    for (int i = 0; i < 6; i++) begin
      status = ~status;
      @(negedge clk);
      check("R2", 4'hF, 2'b00);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_scan(8'b1001_0110, 8*SLOT, -1, 8'h00);  // R6 mixed pairs, two periods (R4)
    t_disable();
    t_scan(8'hFF, 4*SLOT, -1, 8'h00);         // R7 all on
    t_disable();
    t_scan(8'h00, 4*SLOT, -1, 8'h00);         // R7 all off
    t_disable();
    t_scan(8'hA5, 5*SLOT, -1, 8'h00);         // R9 restart at row 0
    t_disable();
    // R8: change row0 bits mid slot 0; new value only from slot 4 on
    t_scan(8'b0000_0001, 6*SLOT, SLOT/2, 8'b0000_0010);
    // R8: change row2 bits during row1 slot; visible in slot 2 already
    t_disable();
    t_scan(8'h00, 4*SLOT, SLOT + 3, 8'b0011_0000);
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule